// File: doc/BRIEF.md
# Ping-Pong IN Endpoint Buffer Controller

This block owns the transmit side of one IN endpoint that has two 64-byte packet buffers used in alternation. The CPU fills the buffer it currently owns through a byte write port and then commits it with a byte-count strobe. That single strobe records the packet length, hands the buffer to the bus side and moves the CPU to the other buffer. A buffer-available flag tells the CPU whether it may write. It is the only lock between the CPU and the serial engine, and the CPU never clears it directly.

The bus side is abstract. An IN token either starts a data reply from the oldest committed buffer, together with its index, length and current DATA0/DATA1 toggle, or gets a NAK when nothing is committed. A host ACK releases that buffer and flips the toggle. An error or timeout leaves everything in place so that the next token resends the same data. The serial engine reads the packet bytes through a read port that addresses the buffer being sent.

Top module: `inep_top`

## Requirements
- R1: After rst_ni is released, avail_o is 1, send_o and nak_o are 0, send_tog_o is 0 (DATA0), and no buffer is committed.
- R2: A bc_wr_i pulse while avail_o is 1 stores bc_i as the length of the CPU-owned buffer, commits it and moves the CPU to the other buffer. avail_o stays 1 when that other buffer is free.
- R3: With both buffers committed, avail_o is 0. While avail_o is 0, both bc_wr_i and wr_en_i are ignored, so neither a length nor a byte of a committed buffer changes.
- R4: An in_tok_i pulse gives exactly one of two replies one cycle later. If a buffer is committed, send_o is 1. Otherwise nak_o is 1. The two are never 1 together.
- R5: Buffers go out in commit order. The first commit after reset uses buffer 0, so send_buf_o is 0 for that buffer and 1 for the other, and send_cnt_o carries the stored length.
- R6: ack_i after a data reply releases the sent buffer. avail_o returns to 1 if it was 0, and the next token sends the next committed buffer or gets a NAK.
- R7: err_i after a data reply releases nothing. The next token resends the same buffer with the same length and the same toggle.
- R8: send_tog_o flips only on an ACK that follows an outstanding data reply. An ack_i with no reply outstanding changes nothing.
- R9: bus_reset_i forces send_tog_o to 0 on the next cycle.
- R10: A commit and an ACK in the same cycle both take effect. The freed buffer becomes the CPU's, so avail_o stays 1.
- R11: rd_data_o gives, without a clock, the byte at rd_addr_i of the buffer named by send_buf_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_reset_i | input | 1 | USB bus reset seen; clears the toggle |
| wr_en_i | input | 1 | CPU byte write into the owned buffer |
| wr_addr_i | input | 6 | CPU byte address |
| wr_data_i | input | 8 | CPU byte data |
| bc_wr_i | input | 1 | Byte-count write strobe (commit) |
| bc_i | input | 7 | Packet length, 0 to 64 |
| avail_o | output | 1 | CPU owns a free buffer |
| in_tok_i | input | 1 | IN token addressed to this endpoint |
| ack_i | input | 1 | Host ACK for the last data reply |
| err_i | input | 1 | Host timeout or bad handshake |
| nak_o | output | 1 | Reply NAK to the token |
| send_o | output | 1 | Reply with data |
| send_buf_o | output | 1 | Buffer index being sent |
| send_cnt_o | output | 7 | Length of the packet being sent |
| send_tog_o | output | 1 | Data toggle, 0 = DATA0 |
| rd_addr_i | input | 6 | Serial engine byte address |
| rd_data_o | output | 8 | Byte read from the buffer being sent |

## Verification
A CPU commit and a host ACK can land in the same clock. In that cycle one buffer is committed and the other is released, and the CPU moves onto the buffer that has just been freed. The bench arms one buffer, sends it, and then raises the byte-count strobe and ACK together. It then checks that the flag is still 1 and that the toggle has flipped. Two further tokens must return the newly committed buffer with its length and the new toggle, and then a NAK.

// File: rtl/inep_pkg.sv
package inep_pkg;
  localparam int unsigned NBUF = 2;

  typedef enum logic [1:0] {
    RESP_IDLE,
    RESP_NAK,
    RESP_DATA
  } resp_e;
endpackage

// File: rtl/inep_store.sv
module inep_store #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic              wsel_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rsel_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  import inep_pkg::*;

  logic [DATA_W-1:0] bank_rd [NBUF];

  for (genvar b = 0; b < NBUF; b++) begin : g_bank
    logic [DATA_W-1:0] mem_q [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i && (wsel_i == 1'(b))) mem_q[waddr_i] <= wdata_i;
    end
    assign bank_rd[b] = mem_q[raddr_i];
  end

  assign rdata_o = bank_rd[rsel_i];
endmodule

// File: rtl/inep_own_ctrl.sv
module inep_own_ctrl #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bc_wr_i,
  input  logic [CNT_W-1:0] bc_i,
  input  logic             rel_i,
  output logic             avail_o,
  output logic             cpu_sel_o,
  output logic             tx_sel_o,
  output logic             tx_armed_o,
  output logic [CNT_W-1:0] tx_cnt_o
);
  import inep_pkg::*;

  logic [NBUF-1:0]  armed_q;
  logic [CNT_W-1:0] cnt_q [NBUF];
  logic             cpu_sel_q, tx_sel_q;
  logic             load_ok;

  assign avail_o = ~armed_q[cpu_sel_q];
  assign load_ok = bc_wr_i & avail_o;

  // load_ok implies cpu buffer free, rel_i implies tx buffer armed: distinct bits
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q   <= '0;
      cpu_sel_q <= 1'b0;
      tx_sel_q  <= 1'b0;
      for (int i = 0; i < NBUF; i++) cnt_q[i] <= '0;
    end else begin
      if (load_ok) begin
        armed_q[cpu_sel_q] <= 1'b1;
        cnt_q[cpu_sel_q]   <= bc_i;
        cpu_sel_q          <= ~cpu_sel_q;
      end
      if (rel_i) begin
        armed_q[tx_sel_q] <= 1'b0;
        tx_sel_q          <= ~tx_sel_q;
      end
    end
  end

  assign cpu_sel_o  = cpu_sel_q;
  assign tx_sel_o   = tx_sel_q;
  assign tx_armed_o = armed_q[tx_sel_q];
  assign tx_cnt_o   = cnt_q[tx_sel_q];
endmodule

// File: rtl/inep_tok_seq.sv
module inep_tok_seq #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_reset_i,
  input  logic             in_tok_i,
  input  logic             ack_i,
  input  logic             err_i,
  input  logic             tx_armed_i,
  input  logic             tx_sel_i,
  input  logic [CNT_W-1:0] tx_cnt_i,
  output logic             rel_o,
  output logic             send_o,
  output logic             nak_o,
  output logic             send_buf_o,
  output logic [CNT_W-1:0] send_cnt_o,
  output logic             send_tog_o
);
  import inep_pkg::*;

  resp_e            resp_d;
  logic             inflight_q, tog_q, send_q, nak_q, buf_q;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    resp_d = RESP_IDLE;
    if (in_tok_i) resp_d = tx_armed_i ? RESP_DATA : RESP_NAK;
  end

  assign rel_o = ack_i & inflight_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inflight_q <= 1'b0;
      tog_q      <= 1'b0;
      send_q     <= 1'b0;
      nak_q      <= 1'b0;
      buf_q      <= 1'b0;
      cnt_q      <= '0;
    end else begin
      send_q <= (resp_d == RESP_DATA);
      nak_q  <= (resp_d == RESP_NAK);
      if (rel_o) begin
        inflight_q <= 1'b0;
        tog_q      <= ~tog_q;
      end else if (err_i) begin
        inflight_q <= 1'b0;
      end
      if (resp_d == RESP_DATA) begin
        inflight_q <= 1'b1;
        buf_q      <= tx_sel_i;
        cnt_q      <= tx_cnt_i;
      end
      if (bus_reset_i) begin
        tog_q      <= 1'b0;
        inflight_q <= 1'b0;
      end
    end
  end

  assign send_o     = send_q;
  assign nak_o      = nak_q;
  assign send_buf_o = buf_q;
  assign send_cnt_o = cnt_q;
  assign send_tog_o = tog_q;
endmodule

// File: rtl/inep_top.sv
module inep_top #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_reset_i,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              bc_wr_i,
  input  logic [CNT_W-1:0]  bc_i,
  output logic              avail_o,
  input  logic              in_tok_i,
  input  logic              ack_i,
  input  logic              err_i,
  output logic              nak_o,
  output logic              send_o,
  output logic              send_buf_o,
  output logic [CNT_W-1:0]  send_cnt_o,
  output logic              send_tog_o,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic             ack_ok, cpu_sel, tx_sel, tx_armed;
  logic [CNT_W-1:0] tx_cnt;

  inep_own_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bc_wr_i    (bc_wr_i),
    .bc_i       (bc_i),
    .rel_i      (ack_ok),
    .avail_o    (avail_o),
    .cpu_sel_o  (cpu_sel),
    .tx_sel_o   (tx_sel),
    .tx_armed_o (tx_armed),
    .tx_cnt_o   (tx_cnt)
  );

  inep_tok_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_reset_i (bus_reset_i),
    .in_tok_i    (in_tok_i),
    .ack_i       (ack_i),
    .err_i       (err_i),
    .tx_armed_i  (tx_armed),
    .tx_sel_i    (tx_sel),
    .tx_cnt_i    (tx_cnt),
    .rel_o       (ack_ok),
    .send_o      (send_o),
    .nak_o       (nak_o),
    .send_buf_o  (send_buf_o),
    .send_cnt_o  (send_cnt_o),
    .send_tog_o  (send_tog_o)
  );

  // CPU writes only while it owns a free buffer
  inep_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk_i   (clk_i),
    .we_i    (wr_en_i & avail_o),
    .wsel_i  (cpu_sel),
    .waddr_i (wr_addr_i),
    .wdata_i (wr_data_i),
    .rsel_i  (send_buf_o),
    .raddr_i (rd_addr_i),
    .rdata_o (rd_data_o)
  );
endmodule

// File: rtl/inep_top_chk.sv
module inep_top_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bus_reset_i,
  input logic in_tok_i,
  input logic bc_wr_i,
  input logic ack_ok,
  input logic avail_o,
  input logic send_o,
  input logic nak_o,
  input logic send_tog_o
);
  a_r4_one_reply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(send_o && nak_o));

  a_r4_reply_needs_token: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (send_o || nak_o) |-> $past(in_tok_i));

  a_r3_lock_only_by_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(avail_o) |-> $past(bc_wr_i));

  a_r8_tog_flips_on_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_ok && !bus_reset_i) |=> (send_tog_o != $past(send_tog_o)));

  a_r8_tog_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ack_ok && !bus_reset_i) |=> $stable(send_tog_o));

  a_r9_busrst_data0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_i |=> !send_tog_o);
endmodule

bind inep_top inep_top_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_reset_i (bus_reset_i),
  .in_tok_i    (in_tok_i),
  .bc_wr_i     (bc_wr_i),
  .ack_ok      (ack_ok),
  .avail_o     (avail_o),
  .send_o      (send_o),
  .nak_o       (nak_o),
  .send_tog_o  (send_tog_o)
);

// File: tb/inep_top_test.sv
module inep_top_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bus_reset_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [5:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       bc_wr_i = 1'b0;
  logic [6:0] bc_i = '0;
  logic       in_tok_i = 1'b0, ack_i = 1'b0, err_i = 1'b0;
  logic [5:0] rd_addr_i = '0;
  logic       avail_o, nak_o, send_o, send_buf_o, send_tog_o;
  logic [6:0] send_cnt_o;
  logic [7:0] rd_data_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  inep_top uut (.*);

  // op: 0 idle, 1 commit, 2 token, 3 ack, 4 err, 5 bus reset
  typedef struct packed {
    logic [2:0] op;
    logic [6:0] arg;
    logic       av, sd, nk, bf;
    logic [6:0] ct;
    logic       tg;
    logic [3:0] req;
  } vec_t;

  localparam vec_t VEC [15] = '{
    '{3'd2, 7'd0,  1'b1, 1'b0, 1'b1, 1'b0, 7'd0,  1'b0, 4'd4},  // R4 nak when empty
    '{3'd1, 7'd5,  1'b1, 1'b0, 1'b0, 1'b0, 7'd0,  1'b0, 4'd2},  // R2 second buffer free
    '{3'd2, 7'd0,  1'b1, 1'b1, 1'b0, 1'b0, 7'd5,  1'b0, 4'd5},  // R5 buffer 0 first
    '{3'd4, 7'd0,  1'b1, 1'b0, 1'b0, 1'b0, 7'd0,  1'b0, 4'd7},
    '{3'd2, 7'd0,  1'b1, 1'b1, 1'b0, 1'b0, 7'd5,  1'b0, 4'd7},  // R7 resend same
    '{3'd3, 7'd0,  1'b1, 1'b0, 1'b0, 1'b0, 7'd0,  1'b1, 4'd8},  // R8 flip
    '{3'd2, 7'd0,  1'b1, 1'b0, 1'b1, 1'b0, 7'd0,  1'b1, 4'd6},  // R6 released
    '{3'd1, 7'd7,  1'b1, 1'b0, 1'b0, 1'b0, 7'd0,  1'b1, 4'd2},
    '{3'd1, 7'd64, 1'b0, 1'b0, 1'b0, 1'b0, 7'd0,  1'b1, 4'd3},  // R3 both armed
    '{3'd2, 7'd0,  1'b0, 1'b1, 1'b0, 1'b1, 7'd7,  1'b1, 4'd5},
    '{3'd3, 7'd0,  1'b1, 1'b0, 1'b0, 1'b0, 7'd0,  1'b0, 4'd6},
    '{3'd2, 7'd0,  1'b1, 1'b1, 1'b0, 1'b0, 7'd64, 1'b0, 4'd5},
    '{3'd3, 7'd0,  1'b1, 1'b0, 1'b0, 1'b0, 7'd0,  1'b1, 4'd8},
    '{3'd5, 7'd0,  1'b1, 1'b0, 1'b0, 1'b0, 7'd0,  1'b0, 4'd9},  // R9
    '{3'd2, 7'd0,  1'b1, 1'b0, 1'b1, 1'b0, 7'd0,  1'b0, 4'd4}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(logic [2:0] op, logic [6:0] arg);
    bc_wr_i     = (op == 3'd1);
    bc_i        = arg;
    in_tok_i    = (op == 3'd2);
    ack_i       = (op == 3'd3);
    err_i       = (op == 3'd4);
    bus_reset_i = (op == 3'd5);
    @(posedge clk_i); #1;
    {bc_wr_i, in_tok_i, ack_i, err_i, bus_reset_i} = '0;
  endtask

  task automatic wr_byte(logic [5:0] a, logic [7:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(posedge clk_i); #1;
    wr_en_i = 1'b0;
  endtask

  task automatic chk_send(string req, logic b, logic [6:0] c, logic t);
    chk(req, send_o, 1, "send");
    chk(req, nak_o, 0, "nak");
    chk(req, send_buf_o, b, "buf");
    chk(req, send_cnt_o, c, "cnt");
    chk(req, send_tog_o, t, "tog");
  endtask

  initial begin
    #(4 * 5000);
    if (!done) begin
      n_fail++;
      $display("FAIL R4 watchdog actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(posedge clk_i); #1;
    // R1 reset state
    chk("R1", avail_o, 1, "avail");
    chk("R1", send_o, 0, "send");
    chk("R1", nak_o, 0, "nak");
    chk("R1", send_tog_o, 0, "tog");

    for (int i = 0; i < 15; i++) begin
      step(VEC[i].op, VEC[i].arg);
      chk($sformatf("R%0d", VEC[i].req), avail_o, VEC[i].av, $sformatf("row%0d avail", i));
      chk($sformatf("R%0d", VEC[i].req), send_o, VEC[i].sd, $sformatf("row%0d send", i));
      chk($sformatf("R%0d", VEC[i].req), nak_o, VEC[i].nk, $sformatf("row%0d nak", i));
      chk($sformatf("R%0d", VEC[i].req), send_tog_o, VEC[i].tg, $sformatf("row%0d tog", i));
      if (VEC[i].sd) begin
        chk($sformatf("R%0d", VEC[i].req), send_buf_o, VEC[i].bf, $sformatf("row%0d buf", i));
        chk($sformatf("R%0d", VEC[i].req), send_cnt_o, VEC[i].ct, $sformatf("row%0d cnt", i));
      end
    end

    // R11 data path, R3 lock on bytes and lengths
    for (int a = 0; a < 64; a++) wr_byte(6'(a), 8'(a) ^ 8'hA5);
    step(3'd1, 7'd64);                      // buffer 1
    for (int a = 0; a < 64; a++) wr_byte(6'(a), 8'h3C + 8'(a));
    step(3'd1, 7'd3);                       // buffer 0
    chk("R3", avail_o, 0, "avail both armed");
    wr_byte(6'd0, 8'hFF);
    step(3'd1, 7'd9);
    chk("R3", avail_o, 0, "avail after locked commit");
    step(3'd2, 7'd0);
    chk_send("R5", 1'b1, 7'd64, 1'b0);
    rd_addr_i = 6'd0;  #1 chk("R3", rd_data_o, 8'hA5, "locked byte kept");
    rd_addr_i = 6'd63; #1 chk("R11", rd_data_o, 8'h63 ^ 8'hA5 ^ 8'h63 ^ 8'd63, "byte 63");
    step(3'd3, 7'd0);
    step(3'd2, 7'd0);
    chk_send("R3", 1'b0, 7'd3, 1'b1);
    rd_addr_i = 6'd2; #1 chk("R11", rd_data_o, 8'h3E, "byte 2");
    step(3'd3, 7'd0);
    step(3'd2, 7'd0);
    chk("R3", nak_o, 1, "no third packet");

    // R8 ack with nothing outstanding
    step(3'd3, 7'd0);
    chk("R8", send_tog_o, 0, "stray ack tog");
    chk("R8", avail_o, 1, "stray ack avail");

    // R10 commit and ack together
    step(3'd1, 7'd4);
    step(3'd2, 7'd0);
    chk_send("R10", 1'b1, 7'd4, 1'b0);
    bc_wr_i = 1'b1; bc_i = 7'd6; ack_i = 1'b1;
    @(posedge clk_i); #1;
    {bc_wr_i, ack_i} = '0;
    chk("R10", avail_o, 1, "avail after commit+ack");
    chk("R10", send_tog_o, 1, "tog after commit+ack");
    step(3'd2, 7'd0);
    chk_send("R10", 1'b0, 7'd6, 1'b1);
    step(3'd3, 7'd0);
    step(3'd2, 7'd0);
    chk("R10", nak_o, 1, "drained");

    // R1 reset mid-stream drops commitments
    step(3'd1, 7'd2);
    step(3'd2, 7'd0);
    #1 rst_ni = 1'b0;
    #1 rst_ni = 1'b1;
    chk("R1", avail_o, 1, "avail after reset");
    chk("R1", send_tog_o, 0, "tog after reset");
    step(3'd2, 7'd0);
    chk("R1", nak_o, 1, "nothing armed after reset");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule